// File: doc/BRIEF.md
# Programmable Priority Interrupt Arbiter

The arbiter picks one winning request out of a bank of interrupt lines. Each line has three per-line settings: a pending bit, a mask bit, and a steering bit that assigns it to the normal class or the fast class. Each line also carries its own five-bit priority value. One select input chooses which class is being arbitrated. A line takes part only if it is pending, not masked, and steered to the selected class. Among the lines that take part, the numerically smallest priority wins. When priorities are equal, the line with the larger number wins.

The comparison is a balanced binary tree of (priority, index) pairs with log2 of the line count stages. The result is either registered once or passed straight through, set by a parameter. When several banks are cascaded, each bank reports its winner as an absolute number: its own bank number times the line count, plus the local line. A valid flag separates a real winner at line 0 from the idle value 0.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A line is a candidate only when its pending bit is 1, its mask bit is 0, and its steering bit equals the class select (select 1 = fast class, takes steering 1; select 0 = normal class, takes steering 0).
- R2: Priority fields are 5 bits, line i using bits [5i+4:5i] of the priority bus. The candidate with the numerically lowest value wins, so 0 is the most urgent.
- R3: Among candidates sharing the lowest priority value, the line with the highest index wins.
- R4: With no candidate, the index output is 0.
- R5: The valid output is 1 exactly when at least one candidate exists, so a winner at line 0 is reported with valid 1.
- R6: The index output equals BANK_NUM*NUM_LINES plus the winning local line number.
- R7: With REGISTERED=1, outputs reflect the inputs sampled at the previous rising clock edge. While rst_n is low, both outputs are 0.
- R8: The priority, pending and steering values of a non-candidate line have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| pend_i | input | NUM_LINES | Pending bit per line |
| mask_i | input | NUM_LINES | Mask bit per line, 1 blocks the line |
| steer_i | input | NUM_LINES | Class steering per line, 1 = fast class |
| class_sel_i | input | 1 | Class being arbitrated, 1 = fast class |
| prio_i | input | NUM_LINES*PRIO_W | Packed per-line priority fields |
| win_idx_o | output | OUT_W | Absolute number of the winning line, 0 when idle |
| win_valid_o | output | 1 | A winner exists |

## Verification
A merge node that uses the wrong comparison shows up at the ports as a wrong index. This happens one clock after any input pattern where two candidates meet in that node, so directed cases pair lines that meet at the leaves, at the middle levels, and at the root. Equal-priority patterns expose a reversed tie rule immediately. Cases with the best-looking priority on a masked or mis-steered line catch a broken filter. Random vectors compared against a linear scan model cover the rest.

// File: rtl/pia_pkg.sv
package pia_pkg;
   typedef enum logic {
      CLASS_NORMAL = 1'b0,
      CLASS_FAST   = 1'b1
   } class_e;

   localparam int unsigned DEF_LINES  = 32;
   localparam int unsigned DEF_PRIO_W = 5;
   localparam int unsigned DEF_BANKS  = 4;
endpackage

// File: rtl/pia_qualify.sv
module pia_qualify
   import pia_pkg::*;
#(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0] pend,
   input  logic [N-1:0] mask,
   input  logic [N-1:0] steer,
   input  class_e       cls,
   output logic [N-1:0] elig
);
   logic [N-1:0] class_match;

   for (genvar g = 0; g < N; g++) begin : g_line
      assign class_match[g] = (steer[g] == logic'(cls));
      assign elig[g]        = pend[g] & ~mask[g] & class_match[g];
   end

   always_comb begin
      for (int k = 0; k < N; k++) begin
         if (elig[k]) begin
            assert_elig_R1: assert (pend[k] && !mask[k] && (steer[k] == logic'(cls)))
               else $error("eligible line %0d fails its qualifiers", k);
         end
      end
   end
endmodule

// File: rtl/pia_merge.sv
module pia_merge #(
   parameter int unsigned PRIO_W = 5,
   parameter int unsigned IDX_W  = 5
) (
   input  logic              a_v,
   input  logic [PRIO_W-1:0] a_p,
   input  logic [IDX_W-1:0]  a_i,
   input  logic              b_v,
   input  logic [PRIO_W-1:0] b_p,
   input  logic [IDX_W-1:0]  b_i,
   output logic              o_v,
   output logic [PRIO_W-1:0] o_p,
   output logic [IDX_W-1:0]  o_i
);
   logic take_b;

   always_comb begin
      if (!b_v)                take_b = 1'b0;
      else if (!a_v)           take_b = 1'b1;
      else if (b_p != a_p)     take_b = (b_p < a_p);
      else                     take_b = (b_i > a_i);
   end

   assign o_v = a_v | b_v;
   assign o_p = take_b ? b_p : a_p;
   assign o_i = take_b ? b_i : a_i;

   always_comb begin
      if (o_v && a_v) begin
         assert_min_a_R2: assert (o_p <= a_p) else $error("node kept worse priority than left");
      end
      if (o_v && b_v) begin
         assert_min_b_R2: assert (o_p <= b_p) else $error("node kept worse priority than right");
      end
      if (a_v && b_v && (a_p == b_p)) begin
         assert_tie_high_R3: assert (o_i >= a_i && o_i >= b_i) else $error("tie not won by higher index");
      end
   end
endmodule

// File: rtl/pia_tree.sv
module pia_tree #(
   parameter int unsigned N      = 32,
   parameter int unsigned PRIO_W = 5
) (
   input  logic [N-1:0]        elig,
   input  logic [N*PRIO_W-1:0] prio,
   output logic                win_v,
   output logic [PRIO_W-1:0]   win_p,
   output logic [$clog2(N)-1:0] win_i
);
   localparam int unsigned IDX_W = $clog2(N);
   localparam int unsigned NODES = 2*N - 1;

   // heap layout: node k has children 2k+1 and 2k+2, leaf i sits at N-1+i
   logic              nv [NODES];
   logic [PRIO_W-1:0] np [NODES];
   logic [IDX_W-1:0]  ni [NODES];

   for (genvar l = 0; l < N; l++) begin : g_leaf
      assign nv[N-1+l] = elig[l];
      assign np[N-1+l] = prio[l*PRIO_W +: PRIO_W];
      assign ni[N-1+l] = IDX_W'(l);
   end

   for (genvar k = 0; k < N-1; k++) begin : g_node
      pia_merge #(
         .PRIO_W (PRIO_W),
         .IDX_W  (IDX_W)
      ) u_merge (
         .a_v (nv[2*k+1]),
         .a_p (np[2*k+1]),
         .a_i (ni[2*k+1]),
         .b_v (nv[2*k+2]),
         .b_p (np[2*k+2]),
         .b_i (ni[2*k+2]),
         .o_v (nv[k]),
         .o_p (np[k]),
         .o_i (ni[k])
      );
   end

   assign win_v = nv[0];
   assign win_p = np[0];
   assign win_i = ni[0];

   always_comb begin
      assert_root_valid_R5: assert (win_v == (|elig)) else $error("root valid disagrees with candidates");
      if (win_v) begin
         assert_root_elig_R1: assert (elig[win_i]) else $error("root picked a non-candidate");
      end
   end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
   import pia_pkg::*;
#(
   parameter int unsigned NUM_LINES  = DEF_LINES,
   parameter int unsigned PRIO_W     = DEF_PRIO_W,
   parameter int unsigned NUM_BANKS  = DEF_BANKS,
   parameter int unsigned BANK_NUM   = 0,
   parameter bit          REGISTERED = 1'b1,
   localparam int unsigned LIDX_W    = $clog2(NUM_LINES),
   localparam int unsigned OUT_W     = $clog2(NUM_LINES*NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LINES-1:0]        pend_i,
   input  logic [NUM_LINES-1:0]        mask_i,
   input  logic [NUM_LINES-1:0]        steer_i,
   input  logic                        class_sel_i,
   input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
   output logic [OUT_W-1:0]            win_idx_o,
   output logic                        win_valid_o
);
   localparam int unsigned BASE = BANK_NUM * NUM_LINES;

   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_chk_lines
      $error("NUM_LINES must be a power of two, at least 2");
   end
   if (PRIO_W < 1) begin : g_chk_prio
      $error("PRIO_W must be at least 1");
   end
   if (NUM_BANKS < 1 || BANK_NUM >= NUM_BANKS) begin : g_chk_bank
      $error("BANK_NUM must be below NUM_BANKS");
   end

   logic [NUM_LINES-1:0] elig;
   logic                 root_v;
   logic [PRIO_W-1:0]    root_p;
   logic [LIDX_W-1:0]    root_i;
   logic [OUT_W-1:0]     comb_idx;

   pia_qualify #(.N(NUM_LINES)) u_qual (
      .pend  (pend_i),
      .mask  (mask_i),
      .steer (steer_i),
      .cls   (class_e'(class_sel_i)),
      .elig  (elig)
   );

   pia_tree #(.N(NUM_LINES), .PRIO_W(PRIO_W)) u_tree (
      .elig  (elig),
      .prio  (prio_i),
      .win_v (root_v),
      .win_p (root_p),
      .win_i (root_i)
   );

   assign comb_idx = root_v ? (OUT_W'(BASE) + OUT_W'(root_i)) : '0;

   if (REGISTERED) begin : g_reg
      logic [OUT_W-1:0]     idx_q;
      logic                 val_q;
      logic [NUM_LINES-1:0] elig_q;
      logic [OUT_W-1:0]     loc;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q  <= '0;
            val_q  <= 1'b0;
            elig_q <= '0;
         end else begin
            idx_q  <= comb_idx;
            val_q  <= root_v;
            elig_q <= elig;
         end
      end

      assign win_idx_o   = idx_q;
      assign win_valid_o = val_q;
      assign loc         = idx_q - OUT_W'(BASE);

      assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !win_valid_o |-> (win_idx_o == '0));
      assert_valid_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
         win_valid_o == (|elig_q));
      assert_in_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
         win_valid_o |-> (win_idx_o >= OUT_W'(BASE) && loc < OUT_W'(NUM_LINES)));
      assert_winner_elig_R1: assert property (@(posedge clk) disable iff (!rst_n)
         win_valid_o |-> elig_q[loc[LIDX_W-1:0]]);
      assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $stable(comb_idx) && $stable(root_v) |=> (win_idx_o == $past(comb_idx)));
   end else begin : g_comb
      assign win_idx_o   = comb_idx;
      assign win_valid_o = root_v;

      always_comb begin
         if (!win_valid_o) begin
            assert_idle_zero_c_R4: assert (win_idx_o == '0) else $error("idle index not zero");
         end else begin
            assert_in_bank_c_R6: assert (win_idx_o >= OUT_W'(BASE)) else $error("index below bank base");
         end
      end
   end
endmodule

// File: tb/sim_prio_irq_arbiter.sv
module sim_prio_irq_arbiter;
   localparam int unsigned N      = 32;
   localparam int unsigned PW     = 5;
   localparam int unsigned BANKS  = 4;
   localparam int unsigned BANK   = 1;
   localparam int unsigned OW     = $clog2(N*BANKS);
   localparam int unsigned BASE   = BANK * N;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      pend = '0;
   logic [N-1:0]      mask = '1;
   logic [N-1:0]      steer = '0;
   logic              cls = 1'b0;
   logic [N*PW-1:0]   prio = '0;
   logic [OW-1:0]     win_idx;
   logic              win_valid;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   prio_irq_arbiter #(
      .NUM_LINES (N),
      .PRIO_W    (PW),
      .NUM_BANKS (BANKS),
      .BANK_NUM  (BANK),
      .REGISTERED(1'b1)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend_i      (pend),
      .mask_i      (mask),
      .steer_i     (steer),
      .class_sel_i (cls),
      .prio_i      (prio),
      .win_idx_o   (win_idx),
      .win_valid_o (win_valid)
   );

   task automatic check(input string req, input logic [OW-1:0] exp_idx, input logic exp_v);
      n_checks++;
      if (win_idx !== exp_idx || win_valid !== exp_v) begin
         n_fail++;
         $display("FAIL %s: idx=%0d valid=%0d expected idx=%0d valid=%0d",
                  req, win_idx, win_valid, exp_idx, exp_v);
      end
   endtask

   // linear scan model; <= keeps the last (highest) index on ties
   task automatic model(output logic [OW-1:0] idx, output logic v);
      int best = 1 << PW;
      int who  = -1;
      for (int i = 0; i < N; i++) begin
         if (pend[i] && !mask[i] && (steer[i] == cls)) begin
            if (int'(prio[i*PW +: PW]) <= best) begin
               best = int'(prio[i*PW +: PW]);
               who  = i;
            end
         end
      end
      v   = (who >= 0);
      idx = v ? OW'(BASE + who) : '0;
   endtask

   task automatic apply_check(input string req);
      logic [OW-1:0] e_idx;
      logic          e_v;
      model(e_idx, e_v);
      @(negedge clk);
      check(req, e_idx, e_v);
   endtask

   task automatic set_prio(input int line, input int val);
      prio[line*PW +: PW] = PW'(val);
   endtask

   task automatic t_reset;
      pend = '1; mask = '0; steer = '0; cls = 1'b0;
      @(negedge clk);
      check("R7 reset", '0, 1'b0);
      rst_n = 1'b1;
      pend = '0; mask = '1;
      @(negedge clk);
      check("R7 after reset", '0, 1'b0);
   endtask

   task automatic t_latency;
      pend = '0; mask = '0; steer = '0; cls = 1'b0; prio = '0;
      @(negedge clk);
      pend[9] = 1'b1;
      #1 check("R7 holds old value before edge", '0, 1'b0);
      @(negedge clk);
      check("R7 one cycle", OW'(BASE + 9), 1'b1);
   endtask

   task automatic t_line_zero;
      pend = '0; mask = '0; steer = '0; cls = 1'b0; prio = '1;
      pend[0] = 1'b1;
      apply_check("R5 line 0 valid");
      pend = '0;
      apply_check("R4 none pending");
      pend = '1; mask = '1;
      apply_check("R4 all masked");
   endtask

   task automatic t_priority;
      pend = '0; mask = '0; steer = '0; cls = 1'b0; prio = '1;
      pend[3] = 1'b1; set_prio(3, 2);
      pend[28] = 1'b1; set_prio(28, 7);
      @(negedge clk);
      check("R2 lower value wins over higher index", OW'(BASE + 3), 1'b1);
      set_prio(28, 0);
      @(negedge clk);
      check("R2 zero most urgent", OW'(BASE + 28), 1'b1);
      pend[16] = 1'b1; set_prio(16, 1); set_prio(28, 31); set_prio(3, 30);
      @(negedge clk);
      check("R2 across root", OW'(BASE + 16), 1'b1);
      pend[17] = 1'b1; set_prio(17, 1);
      @(negedge clk);
      check("R2 sibling", OW'(BASE + 17), 1'b1);
   endtask

   task automatic t_ties;
      pend = '1; mask = '0; steer = '0; cls = 1'b0; prio = '0;
      @(negedge clk);
      check("R3 all equal", OW'(BASE + 31), 1'b1);
      prio = '1;
      mask[31] = 1'b1; mask[30] = 1'b1;
      @(negedge clk);
      check("R3 all equal masked top", OW'(BASE + 29), 1'b1);
      pend = '0; pend[0] = 1'b1; pend[1] = 1'b1; pend[15] = 1'b1;
      set_prio(15, 9); set_prio(0, 4); set_prio(1, 4);
      @(negedge clk);
      check("R3 leaf pair tie", OW'(BASE + 1), 1'b1);
      pend[16] = 1'b1; set_prio(16, 4);
      @(negedge clk);
      check("R3 root tie", OW'(BASE + 16), 1'b1);
   endtask

   task automatic t_filter;
      pend = '0; mask = '0; steer = '0; cls = 1'b0; prio = '1;
      pend[5] = 1'b1; set_prio(5, 20);
      pend[6] = 1'b1; set_prio(6, 0); mask[6] = 1'b1;
      pend[7] = 1'b1; set_prio(7, 0); steer[7] = 1'b1;
      set_prio(8, 0);
      @(negedge clk);
      check("R1 R8 normal class ignores masked, steered, idle", OW'(BASE + 5), 1'b1);
      cls = 1'b1;
      @(negedge clk);
      check("R1 fast class takes steered line", OW'(BASE + 7), 1'b1);
      steer[7] = 1'b0;
      @(negedge clk);
      check("R1 fast class with no steered line", '0, 1'b0);
      steer = '1; mask[6] = 1'b0;
      @(negedge clk);
      check("R1 fast class ties", OW'(BASE + 7), 1'b1);
   endtask

   task automatic t_random;
      for (int r = 0; r < 400; r++) begin
         pend  = $urandom;
         mask  = $urandom;
         steer = $urandom;
         cls   = 1'($urandom);
         for (int i = 0; i < N; i++) begin
            set_prio(i, (r % 3 == 0) ? int'($urandom % 3) : int'($urandom % 32));
         end
         apply_check("R1 R2 R3 R6 random");
      end
   endtask

   initial begin
      #1600000;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_latency();
      t_line_zero();
      t_priority();
      t_ties();
      t_filter();
      t_random();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule